// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

After reset this block stays quiet until a start pulse arrives. It then walks a DDR2 memory through its power-up command sequence on a command interface: a chip-select/row/column/write-enable command code, a bank address and a row/mode address. It also drives the clock-enable line. Commands are one cycle wide. Between commands the block drives NOP for a programmable number of cycles. Each gap is a parameter, so the same block can serve several clock rates.

The sequence has eleven steps. It waits with clock-enable low, then raises clock-enable and waits again. It then precharges all banks and writes extended mode registers 2, 3 and 1 in that order. Next comes a mode-register write that resets the DLL, followed by a second precharge-all and two refreshes. The last step is a mode-register write that leaves the DLL-reset bit clear. When the last gap has elapsed, `init_done` goes high and stays high. From then on an internal timer raises `refresh_req` once per refresh period. The request stays high until `refresh_ack` is asserted. If a period expires while a request is still unacknowledged, a sticky overflow flag is set.

None of the pins carries a data stream, so there is no valid/ready handshake. The command outputs are always driven and the memory cannot stall them. All pins are plain control and status.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: While reset is held, and afterwards until a start pulse arrives, `cke`=0, `cmd`=NOP (4'b0111), `ba`=0, `addr`=0, and `init_done`, `refresh_req` and `refresh_overflow` are 0.
- R2: `cmd` is the 4-bit value {cs_n, ras_n, cas_n, we_n}, with NOP=0111, PRECHARGE=0010, REFRESH=0001 and MODE-REGISTER=0000. The commands appear in this order: NOP, NOP, PRECHARGE, MODE, MODE, MODE, MODE, PRECHARGE, REFRESH, REFRESH, MODE. Every other cycle carries NOP with `ba`=0 and `addr`=0.
- R3: The four MODE commands of steps 3 to 6 use `ba`=2, 3, 1 and 0 in that order, and the final MODE command uses `ba`=0. Every PRECHARGE drives `addr[10]`=1 (all banks), and no other `addr` bit is set.
- R4: Each command follows the previous one after exactly that step's gap parameter. The gaps are: power-up wait after the first NOP, clock-enable wait after the second NOP, precharge wait after each PRECHARGE, tMRD after each MODE, and tRFC after each REFRESH.
- R5: Both plain mode-register writes carry burst length 4 (`addr[2:0]`=010), sequential burst (`addr[3]`=0) and the CAS latency parameter in `addr[6:4]` (3 by default). `addr[8]` (DLL reset) is 1 in the first write and 0 in the second. The extended writes carry `addr`=0.
- R6: `cke` rises on the cycle of the second NOP and stays high. No command other than NOP is issued while `cke` is low.
- R7: `init_done` rises exactly one gap of tMRD after the final MODE command and stays high. Once it is high, only NOP is issued.
- R8: A start pulse has no effect while a sequence is running or after `init_done`.
- R9: `refresh_req` rises every REF_PERIOD cycles counted from the rise of `init_done`, never before it, and stays high until a cycle in which `refresh_ack` is sampled high and no new period expires.
- R10: If the period expires while `refresh_req` is high and `refresh_ack` is low, `refresh_overflow` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| refresh_ack | input | 1 | Clears a pending refresh request |
| cke | output | 1 | Memory clock enable |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Row / mode-register address |
| init_done | output | 1 | Sequence complete |
| refresh_req | output | 1 | Refresh due, held until acknowledged |
| refresh_overflow | output | 1 | Sticky: a refresh period was missed |

## Verification
A behavioural model builds the expected command timeline from the gap list and compares every output on every cycle. The stimulus includes a start pulse that arrives mid-sequence and another that arrives after completion; a design that restarts on either would shift the timeline. The refresh side is first acknowledged a few cycles after a request, which shows both the hold and the release, and is then left unacknowledged across two expiries, which separates a held request from a missed one and sets overflow. Short gap parameters make off-by-one spacing errors in each gap type visible as a timeline shift.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_PREA = 4'b0010,
    CMD_REF  = 4'b0001,
    CMD_MRS  = 4'b0000
  } ddr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } seq_st_e;

  localparam int NUM_STEPS = 11;
  localparam int STEP_W    = $clog2(NUM_STEPS);
endpackage

// File: rtl/ddr2i_step_rom.sv
module ddr2i_step_rom
  import ddr2i_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int CNT_W   = 16,
  parameter int T_PWRUP = 26667,
  parameter int T_CKE   = 54,
  parameter int T_PRE   = 54,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 19,
  parameter int CAS_LAT = 3
) (
  input  logic [STEP_W-1:0] idx,
  output ddr_cmd_e          cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic [CNT_W-1:0]  gap_m1
);
  localparam logic [ADDR_W-1:0] MODE_BASE = ADDR_W'((CAS_LAT << 4) | 2);
  localparam logic [ADDR_W-1:0] DLL_RST   = ADDR_W'(1 << 8);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1 << 10);

  always_comb begin
    cmd    = CMD_NOP;
    ba     = 2'd0;
    addr   = '0;
    cke    = 1'b1;
    gap_m1 = CNT_W'(T_MRD - 1);
    case (idx)
      4'd0:  begin cke = 1'b0; gap_m1 = CNT_W'(T_PWRUP - 1); end
      4'd1:  gap_m1 = CNT_W'(T_CKE - 1);
      4'd2, 4'd7: begin
        cmd = CMD_PREA; addr = ALL_BANKS; gap_m1 = CNT_W'(T_PRE - 1);
      end
      4'd3:  begin cmd = CMD_MRS; ba = 2'd2; end
      4'd4:  begin cmd = CMD_MRS; ba = 2'd3; end
      4'd5:  begin cmd = CMD_MRS; ba = 2'd1; end
      4'd6:  begin cmd = CMD_MRS; addr = MODE_BASE | DLL_RST; end
      4'd8, 4'd9: begin cmd = CMD_REF; gap_m1 = CNT_W'(T_RFC - 1); end
      4'd10: begin cmd = CMD_MRS; addr = MODE_BASE; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2i_wait_ctr.sv
module ddr2i_wait_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (dec && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ddr2i_refresh_timer.sv
module ddr2i_refresh_timer #(
  parameter int PERIOD = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic req,
  output logic ovf
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  logic [CW-1:0] cnt;
  logic          expire;

  assign expire = en && (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      req <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (expire)  cnt <= '0;
      else if (en) cnt <= cnt + 1'b1;
      if (expire)   req <= 1'b1;
      else if (ack) req <= 1'b0;
      if (expire && req && !ack) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
  import ddr2i_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int T_PWRUP    = 26667,
  parameter int T_CKE      = 54,
  parameter int T_PRE      = 54,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 19,
  parameter int CAS_LAT    = 3,
  parameter int REF_PERIOD = 1040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              refresh_ack,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              refresh_req,
  output logic              refresh_overflow
);
  localparam int M_A   = (T_PWRUP > T_CKE) ? T_PWRUP : T_CKE;
  localparam int M_B   = (T_PRE > T_RFC) ? T_PRE : T_RFC;
  localparam int M_C   = (M_A > M_B) ? M_A : M_B;
  localparam int MAX_T = (M_C > T_MRD) ? M_C : T_MRD;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

  seq_st_e           st;
  logic [STEP_W-1:0] idx, nxt_idx;
  logic              gap_zero, issue, finish;
  ddr_cmd_e          r_cmd;
  logic [1:0]        r_ba;
  logic [ADDR_W-1:0] r_addr;
  logic              r_cke;
  logic [CNT_W-1:0]  r_gap;

  assign nxt_idx = (st == ST_IDLE) ? '0 : idx + 1'b1;
  assign issue   = (st == ST_IDLE && start) || (st == ST_RUN && gap_zero && idx != LAST);
  assign finish  = (st == ST_RUN) && gap_zero && (idx == LAST);

  ddr2i_step_rom #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .T_PWRUP(T_PWRUP), .T_CKE(T_CKE),
    .T_PRE(T_PRE), .T_MRD(T_MRD), .T_RFC(T_RFC), .CAS_LAT(CAS_LAT)
  ) u_rom (
    .idx(nxt_idx), .cmd(r_cmd), .ba(r_ba), .addr(r_addr), .cke(r_cke), .gap_m1(r_gap)
  );

  ddr2i_wait_ctr #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(issue), .load_val(r_gap),
    .dec(st == ST_RUN), .zero(gap_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      cmd       <= CMD_NOP;
      ba        <= 2'd0;
      addr      <= '0;
      cke       <= 1'b0;
      init_done <= 1'b0;
    end else begin
      if (issue) begin
        st   <= ST_RUN;
        idx  <= nxt_idx;
        cmd  <= r_cmd;
        ba   <= r_ba;
        addr <= r_addr;
        cke  <= cke | r_cke;
      end else begin
        cmd  <= CMD_NOP;
        ba   <= 2'd0;
        addr <= '0;
      end
      if (finish) begin
        st        <= ST_DONE;
        init_done <= 1'b1;
      end
    end
  end

  ddr2i_refresh_timer #(.PERIOD(REF_PERIOD)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(init_done), .ack(refresh_ack),
    .req(refresh_req), .ovf(refresh_overflow)
  );
endmodule

// File: rtl/ddr2i_checker.sv
module ddr2i_checker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              refresh_ack,
  input logic              cke,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              refresh_req,
  input logic              refresh_overflow
);
  a_r6_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  a_r6_no_cmd_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd == 4'b0111);
  a_r3_precharge_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0010 |-> addr[10]);
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cmd == 4'b0111);
  a_r9_no_req_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req);
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req && !refresh_ack |=> refresh_req);
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_overflow |=> refresh_overflow);
endmodule

bind ddr2_bringup_seq ddr2i_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_ack(refresh_ack), .cke(cke), .cmd(cmd),
  .addr(addr), .init_done(init_done), .refresh_req(refresh_req),
  .refresh_overflow(refresh_overflow)
);

// File: tb/ddr2_bringup_seq_test.sv
module ddr2_bringup_seq_test;
  localparam int AW = 14;
  localparam int P  = 30;
  localparam int NSTEP = 11;
  // gaps per step, in issue order
  localparam int GAP [NSTEP] = '{20, 5, 4, 2, 2, 2, 2, 4, 6, 6, 2};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack = 1'b0;
  logic cke, init_done, req, ovf;
  logic [3:0] cmd;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int total_checks = 0, bad_checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ddr2_bringup_seq #(
    .ADDR_W(AW), .T_PWRUP(20), .T_CKE(5), .T_PRE(4), .T_MRD(2), .T_RFC(6),
    .CAS_LAT(3), .REF_PERIOD(P)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .refresh_ack(ack), .cke(cke),
    .cmd(cmd), .ba(ba), .addr(addr), .init_done(init_done),
    .refresh_req(req), .refresh_overflow(ovf)
  );

  function automatic int offset_of(int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += GAP[j];
    return s;
  endfunction

  function automatic int step_at(int n);
    for (int k = 0; k < NSTEP; k++) if (offset_of(k) == n) return k;
    return -1;
  endfunction

  task automatic chk(bit ok, string req_tag, int act, int exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // behavioural model state
  bit m_started = 0;
  int m_n = 0;
  bit m_req = 0, m_ovf = 0;

  initial begin
    int total;
    total = offset_of(NSTEP);
    for (int c = 0; c < 260; c++) begin
      int k;
      logic [3:0] e_cmd;
      logic [1:0] e_ba;
      logic [AW-1:0] e_addr;
      bit e_cke, e_done, expire;
      @(negedge clk);
      // expected outputs for the state after the last edge
      k = m_started ? step_at(m_n) : -1;
      e_cmd = 4'b0111; e_ba = 2'd0; e_addr = '0;
      case (k)
        2, 7:  begin e_cmd = 4'b0010; e_addr = AW'(14'h400); end
        3:     begin e_cmd = 4'b0000; e_ba = 2'd2; end
        4:     begin e_cmd = 4'b0000; e_ba = 2'd3; end
        5:     begin e_cmd = 4'b0000; e_ba = 2'd1; end
        6:     begin e_cmd = 4'b0000; e_addr = AW'(14'h132); end
        8, 9:  e_cmd = 4'b0001;
        10:    begin e_cmd = 4'b0000; e_addr = AW'(14'h032); end
        default: ;
      endcase
      e_cke  = m_started && m_n >= GAP[0];
      e_done = m_started && m_n >= total;

      if (c == 2) begin // R1 reset state
        chk(cke == 0 && cmd == 4'b0111 && ba == 0 && addr == 0, "R1 outputs in reset",
            {cke, cmd, ba}, 8'h1C);
        chk(!init_done && !req && !ovf, "R1 flags in reset", {init_done, req, ovf}, 0);
      end
      chk(cmd == e_cmd, "R2 R4 cmd", cmd, e_cmd);
      chk(ba == e_ba && addr == e_addr, "R3 ba/addr", {ba, addr}, {e_ba, e_addr});
      if (k == 6 || k == 10) begin
        chk(addr[2:0] == 3'b010 && addr[3] == 0 && addr[6:4] == 3'd3, "R5 burst/CL",
            addr[6:0], 7'h32);
        chk(addr[8] == (k == 6), "R5 DLL reset bit", addr[8], (k == 6));
      end
      chk(cke == e_cke, "R6 cke", cke, e_cke);
      chk(init_done == e_done, "R7 R8 init_done", init_done, e_done);
      chk(req == m_req, "R9 refresh_req", req, m_req);
      chk(ovf == m_ovf, "R10 overflow", ovf, m_ovf);

      // drive inputs for the next edge
      rst_n = (c >= 3);
      start = (c == 10 || c == 20 || c == 100); // later pulses exercise R8
      ack   = m_started && (m_n == total + P + 3);

      // model the coming edge
      if (!rst_n) begin
        m_started = 0; m_n = 0; m_req = 0; m_ovf = 0;
      end else begin
        if (m_started) m_n++;
        else if (start) begin m_started = 1; m_n = 0; end
        expire = m_started && m_n > total && ((m_n - total) % P == 0);
        if (expire && m_req && !ack) m_ovf = 1;
        if (expire) m_req = 1;
        else if (ack) m_req = 0;
      end
    end
    chk(m_ovf == 1, "R10 overflow reached by stimulus", m_ovf, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      bad_checks++;
      total_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end
endmodule